// File: doc/BRIEF.md
# Coherence Snoop Filter Controller

This block tracks, for one address slice of a shared cache, which private caches hold each line and in what coherence state. Every miss from a core's private cache arrives here as a read or a read-for-ownership. A small set-associative tag array holds, per tracked line, a state (invalid, shared, exclusive, modified) and a presence vector with one bit per core. The tracker is inclusive, so a line held by any core always has an entry here.

From the entry the block picks one of three actions. It can do nothing. It can send a directed snoop to the single owner of an exclusive or modified line. It can send a broadcast invalidate that carries a core mask, so that each core looks up its tags only when its own bit is set. The block then waits for one acknowledgement from every addressed core. After that it writes the new entry and answers the requester with the state it receives. A migratory mode hands a modified line to a reader in modified state and invalidates the old owner. Without that mode, both cores end up shared.

The block handles one transaction at a time. If a miss needs a new entry and its set is full, the block raises a stall and does not take the request.

Top module: `snoop_filter_ctl`

## Requirements
- R1: A request to an untracked line allocates an entry in set `req_addr[SET_W-1:0]` without a snoop. A read is granted exclusive and a read-for-ownership is granted modified. Grant codes on `rsp_state` are 0 invalid, 1 shared, 2 exclusive, 3 modified.
- R2: A read of a shared line is granted shared without a snoop, and the requester joins the presence vector.
- R3: A read of an exclusive line held by another core, or of a modified line held by another core while `mig_en` is 0, sends a directed snoop with `snp_inv`=0 (downgrade) and `snp_bcast`=0. The snoop's one-hot `snp_mask` names the holder. The request is granted shared, and the holder remains a sharer.
- R4: A read of a modified line held by another core while `mig_en` is 1 sends a directed snoop with `snp_inv`=1. The request is granted modified, and only the requester stays present.
- R5: A read-for-ownership of a shared line with other sharers sends one invalidate with `snp_bcast`=1 and `snp_inv`=1. Its mask holds every sharer except the requester. The request is granted modified.
- R6: A read-for-ownership of an exclusive or modified line held by another core sends a directed invalidate to that core. The request is granted modified, with only the requester present.
- R7: A request from a core that is the only holder needs no snoop. A read keeps the current state, and a read-for-ownership is granted modified.
- R8: Every later snoop for a line goes only to the cores that earlier grants left present.
- R9: While snoop acknowledgements are outstanding, `req_ready` stays 0, including for a second request to the same line. The response appears only after every masked core has acknowledged. An acknowledgement from a core outside the mask has no effect.
- R10: A miss whose set has no free way raises `stall_full` with `req_ready` 0 and leaves the set's existing entries unchanged. A hit in that set is still accepted.
- R11: `rsp_valid` stays high with stable `rsp_core` and `rsp_state` until `rsp_ready` is high.
- R12: A snoop is a one-cycle `snp_valid` pulse in the cycle after the request is accepted. A request needing no snoop gets its response in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mig_en | input | 1 | Enables migratory handoff of modified lines on reads |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Line address; low SET_W bits pick the set |
| req_core | input | CW | Requesting core index |
| req_rfo | input | 1 | 1 = read-for-ownership, 0 = read |
| stall_full | output | 1 | Miss blocked because its set is full |
| snp_valid | output | 1 | Snoop pulse |
| snp_addr | output | ADDR_W | Snooped line address |
| snp_mask | output | NC | Cores addressed by the snoop |
| snp_bcast | output | 1 | 1 = masked broadcast, 0 = directed |
| snp_inv | output | 1 | 1 = invalidate, 0 = downgrade to shared |
| ack_valid | input | 1 | Snoop acknowledgement present |
| ack_core | input | CW | Core sending the acknowledgement |
| rsp_valid | output | 1 | Grant response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_core | output | CW | Core that receives the grant |
| rsp_state | output | 2 | Granted state code |

## Verification
Two things can land in the same cycle: snoop acknowledgements being collected, and a new request for the same line arriving. The bench holds `req_valid` high throughout the acknowledgement phase of chosen transactions. It checks `req_ready` at each of those cycles. Before the real acknowledgements, it also injects a stray acknowledgement from an unaddressed core and checks that no response has appeared. The expected presence vector and grant at each step come from a line-state model in the bench. The bench then steps through every core in both migratory modes, issuing both request kinds.

// File: rtl/sf_pkg.sv
package sf_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } lstate_t;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_WAIT = 2'd1,
    F_RESP = 2'd2
  } fsm_t;

  // a line with a single permitted holder
  function automatic logic single_owner(lstate_t s);
    return (s == LS_E) || (s == LS_M);
  endfunction

endpackage

// File: rtl/sf_lookup.sv
module sf_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 4
) (
  input  logic [WAYS-1:0]            way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [$clog2(WAYS)-1:0]    hit_way,
  output logic                       free_any,
  output logic [$clog2(WAYS)-1:0]    free_way
);
  localparam int WW = $clog2(WAYS);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_vld[g] && (way_tag[g] == req_tag);
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WW'(w);
      if (!way_vld[w]) free_way = WW'(w);
    end
  end

  assign hit      = |hit_vec;
  assign free_any = ~&way_vld;

endmodule

// File: rtl/sf_policy.sv
module sf_policy
  import sf_pkg::*;
#(
  parameter int NC = 4,
  parameter int CW = 2
) (
  input  logic          hit,
  input  lstate_t       cur_st,
  input  logic [NC-1:0] cur_pres,
  input  logic [CW-1:0] core,
  input  logic          rfo,
  input  logic          mig_en,
  output logic [NC-1:0] snp_mask,
  output logic          bcast,
  output logic          inv,
  output lstate_t       grant,
  output logic [NC-1:0] new_pres
);
  logic [NC-1:0] self_bit, others;

  assign self_bit = NC'(1) << core;
  assign others   = cur_pres & ~self_bit;

  always_comb begin
    snp_mask = '0;
    bcast    = 1'b0;
    inv      = 1'b0;
    grant    = LS_S;
    new_pres = self_bit;
    if (!hit) begin
      grant = rfo ? LS_M : LS_E;
    end else if (others == '0) begin
      grant = rfo ? LS_M : cur_st;
    end else if (rfo) begin
      snp_mask = others;
      bcast    = (cur_st == LS_S);
      inv      = 1'b1;
      grant    = LS_M;
    end else if (!single_owner(cur_st)) begin
      new_pres = cur_pres | self_bit;
    end else if (cur_st == LS_M && mig_en) begin
      snp_mask = others;
      inv      = 1'b1;
      grant    = LS_M;
    end else begin
      snp_mask = others;
      new_pres = others | self_bit;
    end
  end

endmodule

// File: rtl/sf_ack_track.sv
module sf_ack_track #(
  parameter int NC = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NC-1:0] load_mask,
  input  logic          ack_valid,
  input  logic [CW-1:0] ack_core,
  output logic [NC-1:0] pend,
  output logic          last
);
  logic [NC-1:0] ack_bit;

  assign ack_bit = ack_valid ? (NC'(1) << ack_core) : '0;
  assign last    = (pend != '0) && ((pend & ~ack_bit) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    pend <= '0;
    else if (load) pend <= load_mask;
    else           pend <= pend & ~ack_bit;
  end

endmodule

// File: rtl/snoop_filter_ctl.sv
module snoop_filter_ctl
  import sf_pkg::*;
#(
  parameter int NC     = 4,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mig_en,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [$clog2(NC)-1:0]   req_core,
  input  logic                    req_rfo,
  output logic                    stall_full,
  output logic                    snp_valid,
  output logic [ADDR_W-1:0]       snp_addr,
  output logic [NC-1:0]           snp_mask,
  output logic                    snp_bcast,
  output logic                    snp_inv,
  input  logic                    ack_valid,
  input  logic [$clog2(NC)-1:0]   ack_core,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [$clog2(NC)-1:0]   rsp_core,
  output logic [1:0]              rsp_state
);
  localparam int CW    = $clog2(NC);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WW    = $clog2(WAYS);

  fsm_t fsm_q;

  logic [WAYS-1:0]            vld_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  lstate_t                    st_q   [SETS][WAYS];
  logic [NC-1:0]              pres_q [SETS][WAYS];

  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  hit_vec;
  logic             hit, free_any;
  logic [WW-1:0]    hit_way, free_way, use_way;

  assign lk_set  = req_addr[SET_W-1:0];
  assign lk_tag  = req_addr[ADDR_W-1:SET_W];
  assign use_way = hit ? hit_way : free_way;

  sf_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .way_vld (vld_q[lk_set]),
    .way_tag (tag_q[lk_set]),
    .req_tag (lk_tag),
    .hit_vec (hit_vec),
    .hit     (hit),
    .hit_way (hit_way),
    .free_any(free_any),
    .free_way(free_way)
  );

  logic [NC-1:0] pol_mask, pol_pres;
  logic          pol_bcast, pol_inv;
  lstate_t       pol_grant;

  sf_policy #(.NC(NC), .CW(CW)) u_policy (
    .hit     (hit),
    .cur_st  (st_q[lk_set][hit_way]),
    .cur_pres(pres_q[lk_set][hit_way]),
    .core    (req_core),
    .rfo     (req_rfo),
    .mig_en  (mig_en),
    .snp_mask(pol_mask),
    .bcast   (pol_bcast),
    .inv     (pol_inv),
    .grant   (pol_grant),
    .new_pres(pol_pres)
  );

  // named internal events
  logic accept, need_snp, ack_last;
  logic [NC-1:0] ack_pend;

  assign req_ready  = (fsm_q == F_IDLE) && (hit || free_any);
  assign stall_full = (fsm_q == F_IDLE) && req_valid && !hit && !free_any;
  assign accept     = req_valid && req_ready;
  assign need_snp   = (pol_mask != '0);

  sf_ack_track #(.NC(NC), .CW(CW)) u_acks (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept && need_snp),
    .load_mask(pol_mask),
    .ack_valid(ack_valid),
    .ack_core (ack_core),
    .pend     (ack_pend),
    .last     (ack_last)
  );

  // captured transaction
  logic [SET_W-1:0] c_set;
  logic [WW-1:0]    c_way;
  logic [TAG_W-1:0] c_tag;
  lstate_t          c_grant;
  logic [NC-1:0]    c_pres;

  // entry write port
  logic             wr_en, wr_now;
  logic [SET_W-1:0] wr_set;
  logic [WW-1:0]    wr_way;
  logic [TAG_W-1:0] wr_tag;
  lstate_t          wr_state;
  logic [NC-1:0]    wr_pres;

  assign wr_now = accept && !need_snp;
  assign wr_en  = wr_now || ((fsm_q == F_WAIT) && ack_last);

  always_comb begin
    if (wr_now) begin
      wr_set = lk_set;   wr_way = use_way;   wr_tag = lk_tag;
      wr_state = pol_grant;   wr_pres = pol_pres;
    end else begin
      wr_set = c_set;    wr_way = c_way;     wr_tag = c_tag;
      wr_state = c_grant;     wr_pres = c_pres;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      st_q[wr_set][wr_way]   <= wr_state;
      pres_q[wr_set][wr_way] <= wr_pres;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      snp_valid <= 1'b0;
      snp_addr  <= '0;
      snp_mask  <= '0;
      snp_bcast <= 1'b0;
      snp_inv   <= 1'b0;
      rsp_core  <= '0;
      c_set     <= '0;
      c_way     <= '0;
      c_tag     <= '0;
      c_grant   <= LS_I;
      c_pres    <= '0;
    end else begin
      snp_valid <= accept && need_snp;
      case (fsm_q)
        F_IDLE: if (accept) begin
          fsm_q     <= need_snp ? F_WAIT : F_RESP;
          snp_addr  <= req_addr;
          snp_mask  <= pol_mask;
          snp_bcast <= pol_bcast;
          snp_inv   <= pol_inv;
          rsp_core  <= req_core;
          c_set     <= lk_set;
          c_way     <= use_way;
          c_tag     <= lk_tag;
          c_grant   <= pol_grant;
          c_pres    <= pol_pres;
        end
        F_WAIT: if (ack_last) fsm_q <= F_RESP;
        F_RESP: if (rsp_ready) fsm_q <= F_IDLE;
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign rsp_valid = (fsm_q == F_RESP);
  assign rsp_state = c_grant;

  // R1
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R3
  directed_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_bcast |-> $onehot(snp_mask));
  // R6
  owner_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_state == LS_M) |-> $onehot(wr_pres));
  // R9
  snoop_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_WAIT) |-> !req_ready && (ack_pend != '0));
  // R10
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_full |-> !req_ready);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_state) && $stable(rsp_core));
  // R12
  snoop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !snp_valid);

endmodule

// File: tb/snoop_filter_ctl_tb.sv
`timescale 1ns/1ps
module snoop_filter_ctl_tb;
  localparam int NC = 4, SETS = 4, WAYS = 4, ADDR_W = 6;
  localparam int LINES = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0, mig_en = 1'b0;
  logic req_valid = 1'b0, req_rfo = 1'b0, ack_valid = 1'b0, rsp_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_core = '0, ack_core = '0;
  logic req_ready, stall_full, snp_valid, snp_bcast, snp_inv, rsp_valid;
  logic [ADDR_W-1:0] snp_addr;
  logic [NC-1:0] snp_mask;
  logic [1:0] rsp_core, rsp_state;

  always #10 clk = ~clk;

  snoop_filter_ctl #(.NC(NC), .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mig_en(mig_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_core(req_core), .req_rfo(req_rfo), .stall_full(stall_full),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_mask(snp_mask),
    .snp_bcast(snp_bcast), .snp_inv(snp_inv),
    .ack_valid(ack_valid), .ack_core(ack_core),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_core(rsp_core), .rsp_state(rsp_state)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // line model: state code 0 I, 1 S, 2 E, 3 M
  int m_st [LINES];
  int m_pr [LINES];
  int set_cnt [SETS];

  task automatic ceq(input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input int c, input int a, input bit rfo, input bit mig, input bit hold);
    int self_b, oth, e_mask, e_b, e_inv, e_g, e_pr, st;
    string rq;
    st = m_st[a];
    self_b = 1 << c;
    oth = m_pr[a] & ~self_b;
    e_mask = 0; e_b = 0; e_inv = 0; e_pr = self_b;
    if (st == 0) begin
      rq = "R1"; e_g = rfo ? 3 : 2;
    end else if (oth == 0) begin
      rq = "R7"; e_g = rfo ? 3 : st;
    end else if (rfo) begin
      rq = (st == 1) ? "R5" : "R6";
      e_mask = oth; e_b = (st == 1); e_inv = 1; e_g = 3;
    end else if (st == 1) begin
      rq = "R2"; e_g = 1; e_pr = m_pr[a] | self_b;
    end else if (st == 3 && mig) begin
      rq = "R4"; e_mask = oth; e_inv = 1; e_g = 3;
    end else begin
      rq = "R3"; e_mask = oth; e_g = 1; e_pr = oth | self_b;
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = ADDR_W'(a); req_core = 2'(c);
    req_rfo = rfo; mig_en = mig;
    #1 ceq(rq, "req_ready at offer", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = hold;
    if (e_mask != 0) begin
      ceq("R12", "snp_valid after accept", int'(snp_valid), 1);
      ceq(rq, "snp_mask", int'(snp_mask), e_mask);
      ceq("R8", "snp_mask owners", int'(snp_mask), e_mask);
      ceq(rq, "snp_bcast", int'(snp_bcast), e_b);
      ceq(rq, "snp_inv", int'(snp_inv), e_inv);
      ceq(rq, "snp_addr", int'(snp_addr), a);
      // stray acknowledgement from an unaddressed core
      for (int k = 0; k < NC; k++) begin
        if (((e_mask >> k) & 1) == 0) begin
          ack_valid = 1'b1; ack_core = 2'(k);
          @(posedge clk);
          @(negedge clk);
          ack_valid = 1'b0;
          #1 ceq("R9", "rsp after stray ack", int'(rsp_valid), 0);
          break;
        end
      end
      for (int k = 0; k < NC; k++) begin
        if (((e_mask >> k) & 1) != 0) begin
          #1 ceq("R9", "req_ready while acks pending", int'(req_ready), 0);
          if (hold) ceq("R9", "stall_full during wait", int'(stall_full), 0);
          ack_valid = 1'b1; ack_core = 2'(k);
          @(posedge clk);
          @(negedge clk);
          ack_valid = 1'b0;
        end
      end
    end else begin
      ceq("R12", "no snoop pulse", int'(snp_valid), 0);
    end
    #1 ceq(rq, "rsp_valid", int'(rsp_valid), 1);
    ceq(rq, "rsp_core", int'(rsp_core), c);
    ceq(rq, "rsp_state", int'(rsp_state), e_g);
    if (hold) ceq("R9", "req_ready in response", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    ceq("R11", "rsp_valid held", int'(rsp_valid), 1);
    ceq("R11", "rsp_state held", int'(rsp_state), e_g);
    rsp_ready = 1'b1; req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    ceq("R11", "rsp_valid after take", int'(rsp_valid), 0);
    if (st == 0) set_cnt[a % SETS]++;
    m_st[a] = e_g;
    m_pr[a] = e_pr;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_pr[i] = 0; end
    for (int i = 0; i < SETS; i++) set_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 ceq("R12", "reset snp_valid", int'(snp_valid), 0);
    ceq("R11", "reset rsp_valid", int'(rsp_valid), 0);
    ceq("R10", "reset stall_full", int'(stall_full), 0);
    ceq("R9", "reset req_ready", int'(req_ready), 1);

    // directed scenarios on line 1
    do_req(0, 1, 0, 0, 0);   // E grant
    do_req(1, 1, 0, 0, 0);   // downgrade owner
    do_req(2, 1, 0, 0, 0);   // join sharers
    do_req(2, 1, 0, 0, 0);   // re-read
    do_req(3, 1, 1, 0, 1);   // broadcast invalidate, second request held
    do_req(0, 1, 0, 1, 0);   // migratory handoff
    do_req(0, 1, 0, 0, 0);   // sole holder
    do_req(0, 1, 1, 0, 0);
    do_req(1, 1, 0, 0, 1);   // M read, migration off
    // line 2
    do_req(2, 2, 1, 0, 0);
    do_req(1, 2, 1, 0, 0);
    do_req(1, 2, 0, 0, 0);
    // sweep over cores, request kinds and modes
    for (int mg = 0; mg < 2; mg++)
      for (int cc = 0; cc < NC; cc++)
        for (int rf = 0; rf < 2; rf++) begin
          do_req(cc, 3, rf[0], mg[0], cc == 2);
          do_req((cc + 1) % NC, 3, 1'b0, mg[0], 1'b0);
        end

    // set 0 overflow
    for (int w = 0; w < WAYS; w++) do_req(0, w * SETS, 0, 0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = ADDR_W'(WAYS * SETS); req_core = 2'd1; req_rfo = 1'b0;
    #1 ceq("R10", "stall_full on full set", int'(stall_full), 1);
    ceq("R10", "req_ready on full set", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    #1 ceq("R10", "stall_full held", int'(stall_full), 1);
    ceq("R10", "no response to stalled miss", int'(rsp_valid), 0);
    req_valid = 1'b0;
    #1 ceq("R10", "stall_full drops", int'(stall_full), 0);
    do_req(1, 0, 0, 0, 0);   // hit in full set: entry intact, snoops core 0
    do_req(2, SETS, 1, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule